// File: doc/BRIEF.md
# Direct-Load Instruction Fetch Sequencer

This block is the front end of a small multicycle processor. It talks to a byte-wide memory of 64K locations. It drives a 16-bit address from an internal address register and takes the read byte back in the same state. A fetch routine of three states brings each opcode into the instruction register. One of two execute routines then runs, and control always returns to the start of fetch.

Opcode 01h loads the accumulator from a direct 16-bit address. That address is held in the two bytes that follow the opcode, low byte first. The first operand byte is parked in a temporary register until the second byte arrives. The address register then takes the two bytes together as the operand address. Opcode 00h does nothing, and so does every other opcode value. The program counter, accumulator and instruction register are brought out as ports. A strobe marks the first state of every fetch, so a system or a bench can see instruction boundaries.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low and right after it: the program counter, address register and accumulator are zero, `mem_rd_o` is low, and `fetch_begin_o` is high.
- R2: Fetch takes three states. In the first, the address register copies the program counter. In the second, the byte at that address is read and the program counter steps by one. In the third, the byte goes to the instruction register and the address register copies the program counter again.
- R3: Opcode 00h adds one execute state that changes no register. A NOP spans 4 cycles from one `fetch_begin_o` to the next, the accumulator is unchanged, and the program counter ends one past the opcode.
- R4: Any opcode other than 01h behaves exactly as opcode 00h does.
- R5: Opcode 01h adds five execute states. They read the operand byte at opcode+1 as the low half and the byte at opcode+2 as the high half. They then read memory at the combined address and load that byte into the accumulator.
- R6: A load spans 8 cycles from one `fetch_begin_o` to the next, and the program counter ends three past the opcode address.
- R7: `mem_rd_o` is high only in states that capture the memory byte. There is 1 such cycle per NOP-class instruction and 4 per load.
- R8: After each instruction, `ir_o` holds that instruction's opcode byte.
- R9: Operand addresses cover the full 16-bit range, including FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr_o | output | 16 | Memory address, equal to the address register |
| mem_rd_o | output | 1 | High in states that capture `mem_rdata_i` |
| mem_rdata_i | input | 8 | Memory read byte, combinational from `mem_addr_o` |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 16 | Program counter |
| ir_o | output | 8 | Instruction register |
| fetch_begin_o | output | 1 | High in the first fetch state |

## Verification
The bench builds loads whose operand bytes differ, for example 34h/12h and 10h/80h. A design that swapped the byte order would load from 3412h or 1080h and return the wrong accumulator value. A load from FFFFh catches a truncated address path, and a load from 0000h catches a datapath that hides the program bytes. Opcodes 7Eh, 02h and FFh mixed in among NOPs catch a decoder that sends non-01h values into the load routine. Such a design would jump the program counter by three and take 8 cycles. Per-instruction counts of cycles and read strobes show a missing or extra state, and a program counter that forgets to step on the second operand read.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef enum logic [3:0] {
        ST_F1   = 4'd0,
        ST_F2   = 4'd1,
        ST_F3   = 4'd2,
        ST_NOP1 = 4'd3,
        ST_LD1  = 4'd4,
        ST_LD2  = 4'd5,
        ST_LD3  = 4'd6,
        ST_LD4  = 4'd7,
        ST_LD5  = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        AR_HOLD = 2'd0,
        AR_PC   = 2'd1,
        AR_INC  = 2'd2,
        AR_OPND = 2'd3
    } ar_sel_e;

    typedef struct packed {
        ar_sel_e ar_sel;
        logic    pc_inc;
        logic    dr_mem;
        logic    ir_load;
        logic    tr_load;
        logic    ac_load;
    } ctl_word_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] tr;
        logic [DATA_W-1:0] ac;
    } dp_regs_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
    import fetch_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] OP_LOAD = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dr_i,
    output ctl_word_t         ctl_o,
    output logic              fetch_begin_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        ctl_o   = '0;
        unique case (state_q)
            ST_F1: begin
                ctl_o.ar_sel = AR_PC;
                state_d      = ST_F2;
            end
            ST_F2: begin
                ctl_o.dr_mem = 1'b1;
                ctl_o.pc_inc = 1'b1;
                state_d      = ST_F3;
            end
            ST_F3: begin
                ctl_o.ir_load = 1'b1;
                ctl_o.ar_sel  = AR_PC;
                state_d       = (dr_i == OP_LOAD) ? ST_LD1 : ST_NOP1;
            end
            ST_NOP1: state_d = ST_F1;
            ST_LD1: begin
                ctl_o.dr_mem = 1'b1;
                ctl_o.pc_inc = 1'b1;
                ctl_o.ar_sel = AR_INC;
                state_d      = ST_LD2;
            end
            ST_LD2: begin
                ctl_o.tr_load = 1'b1;
                ctl_o.dr_mem  = 1'b1;
                ctl_o.pc_inc  = 1'b1;
                state_d       = ST_LD3;
            end
            ST_LD3: begin
                ctl_o.ar_sel = AR_OPND;
                state_d      = ST_LD4;
            end
            ST_LD4: begin
                ctl_o.dr_mem = 1'b1;
                state_d      = ST_LD5;
            end
            ST_LD5: begin
                ctl_o.ac_load = 1'b1;
                state_d       = ST_F1;
            end
            default: state_d = ST_F1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_F1;
        else        state_q <= state_d;
    end

    assign fetch_begin_o = (state_q == ST_F1);

    // R3: the single no-op execute state hands back to fetch
    assert_nop_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOP1) |=> (state_q == ST_F1));

    // R4: a fetched byte other than the load opcode never enters the load routine
    assert_undef_is_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_F3 && dr_i != OP_LOAD) |=> (state_q == ST_NOP1));

    // R5: operand address formed before the data read
    assert_load_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LD3) |=> (state_q == ST_LD4));

    // R2: fetch states run in sequence
    assert_fetch_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_F1) |=> (state_q == ST_F2));

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
    import fetch_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_word_t         ctl_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output dp_regs_t          regs_o
);

    localparam int OPND_W = 2 * DATA_W;

    dp_regs_t r_q, r_d;
    logic [OPND_W-1:0] opnd_addr;

    assign opnd_addr = {r_q.dr, r_q.tr};

    always_comb begin
        r_d = r_q;
        unique case (ctl_i.ar_sel)
            AR_PC:   r_d.ar = r_q.pc;
            AR_INC:  r_d.ar = r_q.ar + ADDR_W'(1);
            AR_OPND: r_d.ar = ADDR_W'(opnd_addr);
            default: r_d.ar = r_q.ar;
        endcase
        if (ctl_i.pc_inc)  r_d.pc = r_q.pc + ADDR_W'(1);
        if (ctl_i.tr_load) r_d.tr = r_q.dr;
        if (ctl_i.dr_mem)  r_d.dr = mem_rdata_i;
        if (ctl_i.ir_load) r_d.ir = r_q.dr;
        if (ctl_i.ac_load) r_d.ac = r_q.dr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs_o = r_q;

    // R2: program counter steps by exactly one per byte consumed
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.pc_inc |=> (r_q.pc == $past(r_q.pc) + ADDR_W'(1)));

    // R2: address register picks up the program counter
    assert_ar_from_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.ar_sel == AR_PC) |=> (r_q.ar == $past(r_q.pc)));

    // R3: accumulator is left alone outside its load state
    assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_i.ac_load |=> $stable(r_q.ac));

    // R5: first operand byte survives in the temporary register
    assert_tr_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.tr_load |=> (r_q.tr == $past(r_q.dr)));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter logic [7:0] OP_LOAD = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr_o,
    output logic        mem_rd_o,
    input  logic [7:0]  mem_rdata_i,
    output logic [7:0]  acc_o,
    output logic [15:0] pc_o,
    output logic [7:0]  ir_o,
    output logic        fetch_begin_o
);

    ctl_word_t ctl;
    dp_regs_t  regs;

    fetch_seq_ctrl #(.OP_LOAD(OP_LOAD)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .dr_i          (regs.dr),
        .ctl_o         (ctl),
        .fetch_begin_o (fetch_begin_o)
    );

    fetch_seq_dp u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .mem_rdata_i (mem_rdata_i),
        .regs_o      (regs)
    );

    assign mem_addr_o = regs.ar;
    assign mem_rd_o   = ctl.dr_mem;
    assign acc_o      = regs.ac;
    assign pc_o       = regs.pc;
    assign ir_o       = regs.ir;

    // R7: no read strobe in the first fetch state
    assert_no_rd_at_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_begin_o |-> !mem_rd_o);

endmodule

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic [7:0]  acc;
    logic [15:0] pc;
    logic [7:0]  ir;
    logic        fetch_begin;

    always #2.5 clk = ~clk;

    fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_rdata_i(mem_rdata), .acc_o(acc), .pc_o(pc), .ir_o(ir),
        .fetch_begin_o(fetch_begin)
    );

    logic [7:0] mem [logic [15:0]];
    always_comb mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;

    typedef struct {
        logic [7:0]  acc;
        logic [15:0] pc;
        logic [7:0]  ir;
        int          cycles;
        int          reads;
        string       acc_tag;
        string       pc_tag;
    } exp_t;

    exp_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] wp = 16'h0000;
    logic [7:0]  m_acc = 8'h00;
    bit running = 0;
    bit done = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R4/R3: opcodes other than 01h
    task automatic emit_nop(input logic [7:0] op, input string tag);
        exp_t e;
        mem[wp] = op;
        wp = wp + 16'd1;
        e = '{acc: m_acc, pc: wp, ir: op, cycles: 4, reads: 1, acc_tag: tag, pc_tag: "R3"};
        sb.push_back(e);
    endtask

    // R5/R6: direct load, operand low byte first
    task automatic emit_load(input logic [15:0] tgt, input logic [7:0] val, input string tag);
        exp_t e;
        mem[wp] = 8'h01;
        mem[wp + 16'd1] = tgt[7:0];
        mem[wp + 16'd2] = tgt[15:8];
        wp = wp + 16'd3;
        if (!mem.exists(tgt)) mem[tgt] = val;
        m_acc = mem[tgt];
        e = '{acc: m_acc, pc: wp, ir: 8'h01, cycles: 8, reads: 4, acc_tag: tag, pc_tag: "R6"};
        sb.push_back(e);
    endtask

    int cyc = 0;
    int rds = 0;

    always @(negedge clk) begin
        if (running && !done) begin
            if (fetch_begin) begin
                if (cyc != 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.acc_tag, acc, e.acc);
                    check(e.pc_tag, pc, e.pc);
                    check("R8", ir, e.ir);
                    check(e.cycles == 8 ? "R6" : "R3", cyc, e.cycles);
                    check("R7", rds, e.reads);
                    if (sb.size() == 0) done = 1;
                end
                cyc = 1;
                rds = 0;
                check("R7", mem_rd, 0);
            end else begin
                cyc++;
                if (mem_rd) rds++;
                // R2: address register follows the program counter after decode
                if (cyc == 4) check("R2", mem_addr, pc);
            end
        end
    end

    initial begin
        emit_load(16'h1234, 8'hA5, "R5");
        emit_nop(8'h00, "R3");
        emit_load(16'hFFFF, 8'h3C, "R9");
        emit_nop(8'h7E, "R4");
        emit_load(16'h0000, 8'h00, "R5");
        emit_load(16'h8010, 8'h5A, "R5");
        emit_nop(8'h02, "R4");
        emit_nop(8'hFF, "R4");
        emit_load(16'hFFFE, 8'hC3, "R9");
        emit_nop(8'h00, "R3");

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", pc, 16'h0000);
        check("R1", mem_addr, 16'h0000);
        check("R1", acc, 8'h00);
        check("R1", mem_rd, 0);
        check("R1", fetch_begin, 1);
        rst_n = 1'b1;
        running = 1;
    end

    initial begin : watchdog
        int k;
        for (k = 0; k < 2000 && !done; k++) @(posedge clk);
        #1;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d pending expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule